// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block sits between the MAC transmit interface and the line driver of a 10 Mb/s twisted-pair port. It measures how long transmit enable stays asserted without a break. When one transmission lasts longer than a set activation limit, it enters a lockout. During the lockout it holds the transmit path to the line driver inactive, drives collision towards the MAC, and selects normal link pulses for the line in place of data. The lockout lasts for a set unjab period. It does not end while the MAC is still transmitting.

A detection also sets a status bit that stays at one until management reads it through a one-cycle read strobe. A management inhibit input disables detection completely. Both timer limits are parameters counted in clock cycles. With a 10 MHz bit clock (100 ns per cycle) the default limits are 50 ms for activation and 500 ms for unjab.

The controller has four states. IDLE waits for transmit enable. XMIT counts an ongoing transmission. LOCK times the unjab period. DRAIN holds the lockout after the unjab timer has expired until transmit enable falls. The transitions are as follows:
- IDLE goes to XMIT on transmit enable.
- IDLE or XMIT goes to LOCK when the activation limit is reached.
- XMIT goes to IDLE on a deassert.
- LOCK goes to IDLE on expiry when transmit enable is low.
- LOCK goes to DRAIN on expiry when transmit enable is high.
- DRAIN goes to IDLE on a deassert.
- Any state goes to IDLE while inhibit is high.

Top module: `jab_watchdog`

## Requirements
- R1: Outside a lockout, tx_en_o equals tx_en_i and txd_o equals txd_i in the same cycle, and col_o and nlp_sel_o are 0.
- R2: A lockout begins at the clock edge that samples tx_en_i high for the ACT_CYCLES-th consecutive time. After ACT_CYCLES-1 such edges, col_o is still 0.
- R3: During a lockout, tx_en_o is 0 and txd_o is all zeros, whatever the inputs are.
- R4: During a lockout, col_o is 1 and nlp_sel_o is 1.
- R5: jab_stat_o becomes 1 at the edge that starts a lockout. It stays 1, even after the lockout ends, until an edge that samples stat_rd_i high. It reads 0 after that edge.
- R6: While jab_inhibit_i is 1, no lockout starts. Any ongoing lockout is released at once: outputs pass through and col_o is 0.
- R7: If tx_en_i is low when the unjab timer expires, col_o stays 1 for exactly UNJAB_CYCLES cycles.
- R8: If tx_en_i is still high when the unjab timer expires, the lockout continues until the first edge that samples tx_en_i low. col_o is 0 after that edge.
- R9: Any cycle with tx_en_i low restarts the activation count, so two bursts that are each shorter than the limit never cause a lockout.
- R10: If the read strobe and a new detection fall on the same edge, jab_stat_o stays 1.
- R11: After reset, the block is in IDLE with col_o, nlp_sel_o and jab_stat_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| txd_i | input | DW | Transmit data from the MAC |
| jab_inhibit_i | input | 1 | Management inhibit; 1 disables detection |
| stat_rd_i | input | 1 | One-cycle read strobe of the status bit |
| tx_en_o | output | 1 | Gated transmit enable to the line driver |
| txd_o | output | DW | Gated transmit data to the line driver |
| col_o | output | 1 | Collision indication to the MAC |
| nlp_sel_o | output | 1 | Selects normal link pulses on the line |
| jab_stat_o | output | 1 | Latching-high jabber-detected status |

## Verification
The hardest case to reach is the DRAIN state, where the unjab timer has already expired while the MAC is still transmitting. To get there, the bench keeps transmit enable high through the whole activation window and the whole unjab window, with small timer limits. It then checks that the lockout lasts past expiry and ends one edge after the deassert. The read strobe is also placed on the exact edge that starts a lockout, to show that the detection survives the read.

// File: rtl/jab_pkg.sv
package jab_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_XMIT  = 2'd1,
        S_LOCK  = 2'd2,
        S_DRAIN = 2'd3
    } jab_state_e;
endpackage

// File: rtl/jab_timer.sv
module jab_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // done fires on the LIMIT-th consecutive running edge
    assign done_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i || done_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/jab_fsm.sv
module jab_fsm
    import jab_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en_i,
    input  logic       inhibit_i,
    input  logic       act_done_i,
    input  logic       unjab_done_i,
    output logic       act_run_o,
    output logic       unjab_run_o,
    output logic       jab_evt_o,
    output logic       block_o
);
    jab_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (act_done_i)                   state_d = S_LOCK;
                else if (tx_en_i && !inhibit_i)   state_d = S_XMIT;
            end
            S_XMIT: begin
                if (inhibit_i || !tx_en_i)        state_d = S_IDLE;
                else if (act_done_i)              state_d = S_LOCK;
            end
            S_LOCK: begin
                if (inhibit_i)                    state_d = S_IDLE;
                else if (unjab_done_i)            state_d = tx_en_i ? S_DRAIN : S_IDLE;
            end
            S_DRAIN: begin
                if (inhibit_i || !tx_en_i)        state_d = S_IDLE;
            end
            default:                              state_d = S_IDLE;
        endcase
    end

    always_comb begin
        act_run_o   = 1'b0;
        unjab_run_o = 1'b0;
        block_o     = 1'b0;
        unique case (state_q)
            S_IDLE, S_XMIT: act_run_o   = tx_en_i && !inhibit_i;
            S_LOCK:         begin
                                unjab_run_o = !inhibit_i;
                                block_o     = !inhibit_i;
                            end
            S_DRAIN:        block_o     = !inhibit_i;
            default:        block_o     = 1'b0;
        endcase
        jab_evt_o = act_done_i;
    end
endmodule

// File: rtl/jab_status.sv
module jab_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    output logic stat_o
);
    logic stat_q;

    // a set on the same edge as a read wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stat_q <= 1'b0;
        else
            stat_q <= set_i | (stat_q & ~rd_i);
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/jab_watchdog.sv
module jab_watchdog #(
    parameter int unsigned DW           = 4,
    parameter int unsigned ACT_CYCLES   = 500_000,
    parameter int unsigned UNJAB_CYCLES = 5_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en_i,
    input  logic [DW-1:0] txd_i,
    input  logic          jab_inhibit_i,
    input  logic          stat_rd_i,
    output logic          tx_en_o,
    output logic [DW-1:0] txd_o,
    output logic          col_o,
    output logic          nlp_sel_o,
    output logic          jab_stat_o
);
    logic act_run, act_done, unjab_run, unjab_done, jab_evt, block;

    jab_timer #(.LIMIT(ACT_CYCLES)) u_act (
        .clk(clk), .rst_n(rst_n), .run_i(act_run), .done_o(act_done)
    );

    jab_timer #(.LIMIT(UNJAB_CYCLES)) u_unjab (
        .clk(clk), .rst_n(rst_n), .run_i(unjab_run), .done_o(unjab_done)
    );

    jab_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .tx_en_i(tx_en_i), .inhibit_i(jab_inhibit_i),
        .act_done_i(act_done), .unjab_done_i(unjab_done),
        .act_run_o(act_run), .unjab_run_o(unjab_run),
        .jab_evt_o(jab_evt), .block_o(block)
    );

    jab_status u_stat (
        .clk(clk), .rst_n(rst_n),
        .set_i(jab_evt), .rd_i(stat_rd_i), .stat_o(jab_stat_o)
    );

    assign tx_en_o   = tx_en_i && !block;
    assign txd_o     = block ? '0 : txd_i;
    assign col_o     = block;
    assign nlp_sel_o = block;
endmodule

// File: rtl/jab_watchdog_chk.sv
module jab_watchdog_chk #(
    parameter int unsigned DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_en_i,
    input logic          jab_inhibit_i,
    input logic          stat_rd_i,
    input logic          tx_en_o,
    input logic [DW-1:0] txd_o,
    input logic          col_o,
    input logic          nlp_sel_o,
    input logic          jab_stat_o
);
    p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        col_o |-> (!tx_en_o && txd_o == '0));

    p_col_nlp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        col_o == nlp_sel_o);

    p_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        jab_inhibit_i |-> !col_o);

    p_stat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (jab_stat_o && !stat_rd_i) |=> jab_stat_o);

    p_lock_sets_stat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_o) |-> jab_stat_o);

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(col_o) |-> ($past(!tx_en_i) || $past(jab_inhibit_i) || jab_inhibit_i));
endmodule

bind jab_watchdog jab_watchdog_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en_i), .jab_inhibit_i(jab_inhibit_i),
    .stat_rd_i(stat_rd_i), .tx_en_o(tx_en_o), .txd_o(txd_o), .col_o(col_o),
    .nlp_sel_o(nlp_sel_o), .jab_stat_o(jab_stat_o)
);

// File: tb/tb_jab_watchdog.sv
module tb_jab_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 4;
    localparam int ACT   = 16;
    localparam int UNJAB = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en_i = 1'b0;
    logic [DW-1:0] txd_i = '0;
    logic jab_inhibit_i = 1'b0;
    logic stat_rd_i = 1'b0;
    logic tx_en_o, col_o, nlp_sel_o, jab_stat_o;
    logic [DW-1:0] txd_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jab_watchdog #(.DW(DW), .ACT_CYCLES(ACT), .UNJAB_CYCLES(UNJAB)) dut (
        .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en_i), .txd_i(txd_i),
        .jab_inhibit_i(jab_inhibit_i), .stat_rd_i(stat_rd_i),
        .tx_en_o(tx_en_o), .txd_o(txd_o), .col_o(col_o),
        .nlp_sel_o(nlp_sel_o), .jab_stat_o(jab_stat_o)
    );

    // {tx_en, inhibit, txd, hold, exp_col, exp_en, exp_txd, exp_stat}
    localparam int TW = 21;
    localparam logic [TW-1:0] TBL [7] = '{
        {1'b1, 1'b0, 4'h5, 8'd3,  1'b0, 1'b1, 4'h5, 1'b0},
        {1'b1, 1'b0, 4'hA, 8'd4,  1'b0, 1'b1, 4'hA, 1'b0},
        {1'b0, 1'b0, 4'h0, 8'd2,  1'b0, 1'b0, 4'h0, 1'b0},
        {1'b1, 1'b0, 4'h3, 8'd10, 1'b0, 1'b1, 4'h3, 1'b0},
        {1'b0, 1'b0, 4'h0, 8'd1,  1'b0, 1'b0, 4'h0, 1'b0},
        {1'b1, 1'b1, 4'hF, 8'd20, 1'b0, 1'b1, 4'hF, 1'b0},
        {1'b0, 1'b0, 4'h0, 8'd1,  1'b0, 1'b0, 4'h0, 1'b0}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        int n;
        step(2);
        // R11 reset state
        chk(col_o == 1'b0 && nlp_sel_o == 1'b0 && jab_stat_o == 1'b0, "R11",
            {col_o, nlp_sel_o, jab_stat_o}, 0);
        rst_n = 1'b1;
        step(1);

        // table: R1 pass-through, R9 short bursts, R6 inhibit on a long burst
        for (int i = 0; i < 7; i++) begin
            logic [TW-1:0] v;
            v = TBL[i];
            tx_en_i       = v[20];
            jab_inhibit_i = v[19];
            txd_i         = v[18:15];
            step(int'(v[14:7]));
            chk({col_o, tx_en_o, txd_o, jab_stat_o} == v[6:0], "R1/R6/R9 table",
                {col_o, tx_en_o, txd_o, jab_stat_o}, v[6:0]);
        end

        // R2 boundary, then R3/R4/R5 during lockout
        tx_en_i = 1'b1; txd_i = 4'h9;
        step(ACT - 1);
        chk(col_o == 1'b0 && tx_en_o == 1'b1, "R2", col_o, 0);
        step(1);
        chk(col_o == 1'b1, "R2", col_o, 1);
        chk(tx_en_o == 1'b0 && txd_o == '0, "R3", {tx_en_o, txd_o}, 0);
        chk(nlp_sel_o == 1'b1, "R4", nlp_sel_o, 1);
        chk(jab_stat_o == 1'b1, "R5", jab_stat_o, 1);
        // R8: still transmitting at expiry
        step(UNJAB);
        chk(col_o == 1'b1, "R8", col_o, 1);
        step(5);
        chk(col_o == 1'b1 && tx_en_o == 1'b0, "R8", col_o, 1);
        tx_en_i = 1'b0; txd_i = '0;
        step(1);
        chk(col_o == 1'b0, "R8", col_o, 0);
        // R5 latch holds after lockout, clears on read
        step(3);
        chk(jab_stat_o == 1'b1, "R5", jab_stat_o, 1);
        stat_rd_i = 1'b1;
        step(1);
        stat_rd_i = 1'b0;
        chk(jab_stat_o == 1'b0, "R5", jab_stat_o, 0);

        // R7: lockout length with tx_en low
        tx_en_i = 1'b1;
        step(ACT);
        tx_en_i = 1'b0;
        n = 0;
        while (col_o && n < 1000) begin
            n++;
            step(1);
        end
        chk(n == UNJAB, "R7", n, UNJAB);

        // R9: two bursts of ACT-1 separated by one idle cycle
        stat_rd_i = 1'b1; step(1); stat_rd_i = 1'b0;
        tx_en_i = 1'b1; step(ACT - 1);
        tx_en_i = 1'b0; step(1);
        tx_en_i = 1'b1; step(ACT - 1);
        chk(col_o == 1'b0 && jab_stat_o == 1'b0, "R9", {col_o, jab_stat_o}, 0);
        tx_en_i = 1'b0; step(2);

        // R10: read strobe on the detection edge
        tx_en_i = 1'b1; step(ACT - 1);
        stat_rd_i = 1'b1; step(1); stat_rd_i = 1'b0;
        chk(jab_stat_o == 1'b1 && col_o == 1'b1, "R10", {jab_stat_o, col_o}, 3);

        // R6: inhibit releases an ongoing lockout
        txd_i = 4'h6;
        jab_inhibit_i = 1'b1;
        step(1);
        chk(col_o == 1'b0 && tx_en_o == 1'b1 && txd_o == 4'h6, "R6",
            {col_o, tx_en_o, txd_o}, 6'h16);
        tx_en_i = 1'b0; txd_i = '0;
        step(1);
        jab_inhibit_i = 1'b0;
        step(1);
        chk(col_o == 1'b0 && nlp_sel_o == 1'b0, "R6", col_o, 0);
        tx_en_i = 1'b1; txd_i = 4'hC;
        step(2);
        chk(tx_en_o == 1'b1 && txd_o == 4'hC, "R1", {tx_en_o, txd_o}, 5'h1C);
        tx_en_i = 1'b0;
        step(2);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected done", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule